// File: doc/BRIEF.md
# Dual-Mode Serial Clock Divider

This block derives the serial-clock timing of a serial peripheral master from the module clock. A 13-bit control word holds two divisor fields and a select bit. In linear mode the serial clock runs at the module clock divided by 2×(n+1). In exponential mode it runs at the module clock divided by a power of two set by a 4-bit exponent. The transfer engine drives a run enable. While run is high the divider emits a one-cycle pulse at every half period, a serial-clock level that toggles on each pulse, and a full-period pulse on every second half-period pulse. The shift engine uses these pulses to launch and sample data.

The divide counter is held at zero while run is low, so every burst begins with a full half period before the first pulse. The control word is captured only while run is low. A setting written during a burst therefore takes effect at the next burst start.

Top module: `spi_sclk_div`

## Requirements
- R1: With bit 12 of the control word at 1 (linear mode), the half period is n+1 module-clock cycles, where n is bits 7:0. n = 0 gives a half-pulse every cycle.
- R2: With bit 12 at 0 (exponential mode), the half period is 2^(e−1) module-clock cycles, where e is bits 11:8 and 1 ≤ e ≤ 15.
- R3: In exponential mode, e = 0 gives the same timing as e = 1: a half-pulse every module-clock cycle.
- R4: The field that the select bit does not choose has no effect on timing. In linear mode bits 11:8 are ignored; in exponential mode bits 7:0 are ignored.
- R5: While run is low the counter is held at zero. One cycle after run is sampled low, the half pulse, the period pulse and the serial-clock level are all low, and they stay low.
- R6: The first half pulse of a burst appears exactly H cycles after run is first sampled high, where H is the half period.
- R7: The serial-clock level starts low at each burst and toggles on every half pulse, giving a 50 % duty cycle.
- R8: The period pulse is high only together with a half pulse. It marks every second half pulse of a burst, the ones on which the serial clock returns low.
- R9: The control word is captured only in cycles where run is low. A change made while run is high does not alter the current burst's timing; it applies from the next burst.
- R10: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Burst enable from the transfer engine |
| div_cfg_i | input | 13 | Control word: [7:0] linear divisor, [11:8] exponent, [12] mode select (1 = linear) |
| sclk_o | output | 1 | Serial-clock level, idle low |
| half_tick_o | output | 1 | One-cycle pulse at each half period |
| period_tick_o | output | 1 | One-cycle pulse at each full period (falling serial-clock edge) |

## Verification
The assertions assume that the control word never has to be stable during a burst. They check that the latched limit stays frozen on its own, whatever the input does. They also assume that run is a clean synchronous level, and that the counter-bound and pulse-spacing properties are read against the limit latched when run was last low. The stimulus changes the control word and run only at falling clock edges. It holds run low for at least two cycles before each burst, and it changes the control word inside a burst on purpose to test that the change is ignored.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

   // Mode select bit value in the control word
   typedef enum logic {
      DIV_MODE_EXP = 1'b0,
      DIV_MODE_LIN = 1'b1
   } div_mode_e;

   // Counter width needed for both divide laws
   function automatic int unsigned div_cnt_width(input int unsigned lin_w,
                                                 input int unsigned exp_w);
      int unsigned exp_bits;
      exp_bits = (1 << exp_w) - 2;
      if (exp_bits < 1) exp_bits = 1;
      return (lin_w > exp_bits) ? lin_w : exp_bits;
   endfunction

endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
   import spi_div_pkg::*;
#(
   parameter int unsigned LIN_W  = 8,
   parameter int unsigned EXP_W  = 4,
   parameter bit          EXP_EN = 1'b1,
   parameter int unsigned CNT_W  = div_cnt_width(LIN_W, EXP_W),
   localparam int unsigned CFG_W = LIN_W + EXP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic [CNT_W-1:0] lim_o
);

   logic [LIN_W-1:0] lin_fld;
   logic [EXP_W-1:0] exp_fld;
   div_mode_e        mode;
   logic [CNT_W-1:0] lin_lim;
   logic [CNT_W-1:0] exp_lim;
   logic [CNT_W-1:0] dec_lim;

   assign lin_fld = cfg_i[LIN_W-1:0];
   assign exp_fld = cfg_i[LIN_W +: EXP_W];
   assign mode    = div_mode_e'(cfg_i[LIN_W+EXP_W]);
   assign lin_lim = CNT_W'(lin_fld);

   generate
      if (EXP_EN) begin : g_exp
         logic [CNT_W-1:0] one;
         logic [EXP_W-1:0] sh;
         assign one = CNT_W'(1);
         assign sh  = exp_fld - EXP_W'(1);
         // exponent 0 clamps to the fastest rate, same as exponent 1
         assign exp_lim = (exp_fld == '0) ? '0 : ((one << sh) - one);
      end else begin : g_lin_only
         assign exp_lim = lin_lim;
      end
   endgenerate

   assign dec_lim = (mode == DIV_MODE_LIN) ? lin_lim : exp_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lim_o <= '0;
      else if (!run_i) lim_o <= dec_lim;
   end

   // R9
   lim_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run_i) |-> $stable(lim_o));

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] lim_i,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt;

   assign wrap_o = run_i && (cnt >= lim_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run_i) cnt <= '0;
      else if (wrap_o) cnt <= '0;
      else             cnt <= cnt + CNT_W'(1);
   end

   // R1
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= lim_i);

   // R5
   cnt_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt == '0));

endmodule

// File: rtl/spi_div_edge.sv
module spi_div_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic wrap_i,
   output logic sclk_o,
   output logic half_o,
   output logic period_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_o   <= 1'b0;
         half_o   <= 1'b0;
         period_o <= 1'b0;
      end else if (!run_i) begin
         sclk_o   <= 1'b0;
         half_o   <= 1'b0;
         period_o <= 1'b0;
      end else begin
         sclk_o   <= sclk_o ^ wrap_i;
         half_o   <= wrap_i;
         period_o <= wrap_i & sclk_o;
      end
   end

   // R8
   period_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_o |-> half_o);

   // R7
   toggle_on_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_o && $past(run_i)) |-> (sclk_o != $past(sclk_o)));

   // R5
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (!sclk_o && !half_o && !period_o));

endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
   import spi_div_pkg::*;
#(
   parameter int unsigned LIN_W  = 8,
   parameter int unsigned EXP_W  = 4,
   parameter bit          EXP_EN = 1'b1,
   localparam int unsigned CFG_W = LIN_W + EXP_W + 1,
   localparam int unsigned CNT_W = div_cnt_width(LIN_W, EXP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CFG_W-1:0] div_cfg_i,
   output logic             sclk_o,
   output logic             half_tick_o,
   output logic             period_tick_o
);

   generate
      if (LIN_W < 1 || LIN_W > 16) begin : g_bad_lin
         $error("LIN_W out of range");
      end
      if (EXP_W < 1 || EXP_W > 5) begin : g_bad_exp
         $error("EXP_W out of range");
      end
   endgenerate

   logic [CNT_W-1:0] lim;
   logic             wrap;

   spi_div_cfg #(
      .LIN_W (LIN_W),
      .EXP_W (EXP_W),
      .EXP_EN(EXP_EN),
      .CNT_W (CNT_W)
   ) i_cfg (
      .clk  (clk),
      .rst_n(rst_n),
      .run_i(run_i),
      .cfg_i(div_cfg_i),
      .lim_o(lim)
   );

   spi_div_count #(
      .CNT_W(CNT_W)
   ) i_count (
      .clk   (clk),
      .rst_n (rst_n),
      .run_i (run_i),
      .lim_i (lim),
      .wrap_o(wrap)
   );

   spi_div_edge i_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (run_i),
      .wrap_i  (wrap),
      .sclk_o  (sclk_o),
      .half_o  (half_tick_o),
      .period_o(period_tick_o)
   );

   // R6
   half_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (half_tick_o && lim != '0) |=> !half_tick_o);

endmodule

// File: tb/test_spi_sclk_div.sv
module test_spi_sclk_div;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 9;

   typedef struct packed {
      logic [12:0] cfg;
      logic [15:0] half;
   } vec_t;

   // control word, expected half period
   localparam vec_t VECS [NVEC] = '{
      '{13'h1000, 16'd1},    // R1 linear n=0
      '{13'h1003, 16'd4},    // R1 linear n=3
      '{13'h10FF, 16'd256},  // R1 linear n=255
      '{13'h0000, 16'd1},    // R3 exponent 0
      '{13'h0100, 16'd1},    // R2 exponent 1
      '{13'h0400, 16'd8},    // R2 exponent 4
      '{13'h0900, 16'd256},  // R2 exponent 9
      '{13'h1507, 16'd8},    // R4 exponent field ignored
      '{13'h03AA, 16'd4}     // R4 linear field ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [12:0] cfg = '0;
   logic        sclk, half, period;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_sclk_div i_spi_sclk_div (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .div_cfg_i    (cfg),
      .sclk_o       (sclk),
      .half_tick_o  (half),
      .period_tick_o(period)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // start a burst and measure the first two half pulses
   task automatic burst(input logic [12:0] c, input int h, input string req);
      int first = 0, second = 0;
      int s1 = 0, p1 = 0, s2 = 0, p2 = 0;
      @(negedge clk); run = 1'b0; cfg = c;
      repeat (2) @(negedge clk);
      run = 1'b1;
      for (int i = 1; i <= 2*h + 2; i++) begin
         @(negedge clk);
         if (half) begin
            if (first == 0) begin first = i; s1 = sclk; p1 = period; end
            else if (second == 0) begin second = i; s2 = sclk; p2 = period; end
         end
      end
      chk(first == h, {req, " R6 first half pulse"}, first, h);
      chk(second == 2*h, {req, " second half pulse"}, second, 2*h);
      chk(s1 == 1 && s2 == 0, "R7 sclk level after pulses", s1*10 + s2, 10);
      chk(p1 == 0 && p2 == 1, "R8 period pulse on second half", p1*10 + p2, 1);
      run = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int cnt;
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(!sclk && !half && !period, "R10 outputs in reset", {sclk, half, period}, 0);
      rst_n = 1'b1;

      for (int v = 0; v < NVEC; v++)
         burst(VECS[v].cfg, int'(VECS[v].half), $sformatf("R1/R2 vec%0d", v));

      // R2 largest exponent
      burst(13'h0F00, 16384, "R2 exponent 15");

      // R5 idle: run low, no activity
      @(negedge clk); run = 1'b0; cfg = 13'h1000;
      cnt = 0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (half || period || sclk) cnt++;
      end
      chk(cnt == 0, "R5 activity while idle", cnt, 0);

      // R5 dropping run mid-burst quiets outputs after one cycle
      run = 1'b1;
      repeat (3) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      chk(!sclk && !half && !period, "R5 quiet after run low", {sclk, half, period}, 0);

      // R9 mid-burst change ignored
      @(negedge clk); cfg = 13'h1003;
      repeat (2) @(negedge clk);
      run = 1'b1;
      cnt = 0;
      for (int i = 1; i <= 4; i++) begin
         @(negedge clk);
         if (i == 1) cfg = 13'h1000;
         if (half) cnt++;
      end
      chk(cnt == 1, "R9 half pulses in 4 cycles after change", cnt, 1);
      cnt = 0;
      for (int i = 5; i <= 8; i++) begin
         @(negedge clk);
         if (half) cnt = i;
      end
      chk(cnt == 8, "R9 second pulse keeps old period", cnt, 8);
      // R9 new setting applies at next burst
      run = 1'b0;
      repeat (2) @(negedge clk);
      run = 1'b1;
      @(negedge clk);
      chk(half == 1'b1, "R9 new period at next burst", half, 1);
      @(negedge clk);
      chk(half == 1'b1 && period == 1'b1, "R8 period on second pulse", {half, period}, 3);
      run = 1'b0;

      // R10 reset mid-burst
      run = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(!sclk && !half && !period, "R10 outputs after reset", {sclk, half, period}, 0);
      run = 1'b0;
      rst_n = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule